// File: doc/BRIEF.md
# Oscillator Rate Trimming Prescaler

The block divides a 32.768 kHz clock down to a one-second enable for the time counters. It compensates a crystal that runs fast or slow by lengthening or shortening one second in every correction interval. The amount comes from a 7-bit adjustment code held in a local register. A code with the top bit clear lengthens the correction second, so fewer seconds are counted over time. A code with the top bit set shortens it. One step of the code is one oscillator count per ten-second interval, which is about 3.05 ppm.

The code is read as a two's complement number v. For v from 2 to 63 the correction second takes v-1 extra counts. For v from -1 to -62 it takes |v| fewer counts. The four codes 0, 1, -64 and -63 apply no correction. A level on the halt input clears the register at once, with no clock needed, so the block falls back to plain division whenever the oscillator has stopped. The raw clock is also passed straight through, and no correction ever touches it.

Top module: `osc_trim_top`

## Requirements
- R1: After reset the second counter restarts. The first `tick_o` pulse comes DIV-1 rising edges after reset is released. Every `tick_o` pulse is high for exactly one clock cycle.
- R2: Seconds are numbered 0 to INTERVAL-1 from reset, and the numbering wraps. Only second INTERVAL-1 of each interval can be corrected. Every other second is exactly DIV cycles long.
- R3: With bit 6 clear and code value v from 2 to 63 (0000010 to 0111111), the correction second lasts DIV+v-1 cycles.
- R4: With bit 6 set, the code is taken as two's complement v from -1 to -62 (1111111 to 1000010). The correction second then lasts DIV+v cycles, that is, |v| counts shorter.
- R5: The codes 0000000, 0000001, 1000000 and 1000001 leave the correction second at DIV cycles.
- R6: While `halt_i` is high, the register clears without waiting for a clock and ignores loads. A cleared register applies no correction.
- R7: `clk32_o` always follows `clk_i` directly, whatever the adjustment state.
- R8: `adj_load_i` writes `adj_code_i` into the register on a rising edge. The length of each second is fixed when that second starts, so loading a new code never changes a second that is already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Raw 32.768 kHz oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| halt_i | input | 1 | Oscillation-halt flag; clears the register asynchronously |
| adj_load_i | input | 1 | Write strobe for the adjustment register |
| adj_code_i | input | 7 | Adjustment code; bit 6 is the direction |
| tick_o | output | 1 | Corrected one-second enable, one cycle wide |
| clk32_o | output | 1 | Uncorrected pass-through of `clk_i` |

## Verification
The hardest case to reach is a code change that lands inside a correction second that has already started. Correction seconds come only once per interval, so the bench counts ticks to reach that second and then loads a new code a few cycles into it. It checks that the running second keeps the length of the old code. It then checks that the next interval's correction second uses the new code. All 128 codes are also swept, one reset per code, so that every null and boundary code is measured at the ports.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [1:0] {
    TRIM_NONE = 2'd0,
    TRIM_SLOW = 2'd1,
    TRIM_FAST = 2'd2
  } trim_dir_e;
endpackage

// File: rtl/osc_trim_reg.sv
module osc_trim_reg #(
  parameter int CODE_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              load_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] code_o
);
  logic [CODE_W-1:0] code_q;

  // halt clears without a clock edge and wins over load
  always_ff @(posedge clk_i or negedge rst_ni or posedge halt_i) begin
    if (!rst_ni)      code_q <= '0;
    else if (halt_i)  code_q <= '0;
    else if (load_i)  code_q <= code_i;
  end

  assign code_o = code_q;
endmodule

// File: rtl/osc_trim_decode.sv
module osc_trim_decode
  import osc_trim_pkg::*;
#(
  parameter int CODE_W = 7,
  localparam int AMT_W = CODE_W - 1
) (
  input  logic [CODE_W-1:0] code_i,
  output trim_dir_e         dir_o,
  output logic [AMT_W-1:0]  amt_o
);
  localparam int MaxMag = (2 ** (CODE_W - 1)) - 2;

  always_comb begin
    int v;
    v = int'($signed(code_i));
    dir_o = TRIM_NONE;
    amt_o = '0;
    if (v >= 2) begin
      dir_o = TRIM_SLOW;
      amt_o = AMT_W'(v - 1);
    end else if (v <= -1 && v >= -MaxMag) begin
      dir_o = TRIM_FAST;
      amt_o = AMT_W'(-v);
    end
  end
endmodule

// File: rtl/osc_trim_interval.sv
module osc_trim_interval #(
  parameter int INTERVAL = 10,
  localparam int SEC_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [SEC_W-1:0] sec_o,
  output logic             corr_next_o
);
  localparam logic [SEC_W-1:0] SecLast = SEC_W'(INTERVAL - 1);
  localparam logic [SEC_W-1:0] SecPre  = SEC_W'(INTERVAL - 2);

  logic [SEC_W-1:0] sec_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      sec_q <= '0;
    else if (tick_i)  sec_q <= (sec_q == SecLast) ? '0 : sec_q + 1'b1;
  end

  assign sec_o       = sec_q;
  assign corr_next_o = (sec_q == SecPre);
endmodule

// File: rtl/osc_trim_prescaler.sv
module osc_trim_prescaler
  import osc_trim_pkg::*;
#(
  parameter int DIV   = 32768,
  parameter int AMT_W = 6,
  localparam int CNT_W = $clog2(DIV + (2 ** AMT_W))
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  trim_dir_e        dir_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic             corr_next_i,
  output logic             tick_o
);
  localparam logic [CNT_W-1:0] Base = CNT_W'(DIV - 1);

  logic [CNT_W-1:0] cnt_q, lim_q, lim_next;

  always_comb begin
    lim_next = Base;
    if (corr_next_i) begin
      unique case (dir_i)
        TRIM_SLOW: lim_next = Base + CNT_W'(amt_i);
        TRIM_FAST: lim_next = Base - CNT_W'(amt_i);
        default:   lim_next = Base;
      endcase
    end
  end

  assign tick_o = (cnt_q == lim_q);

  // limit for the coming second is frozen at the boundary
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      lim_q <= Base;
    end else if (tick_o) begin
      cnt_q <= '0;
      lim_q <= lim_next;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/osc_trim_top.sv
module osc_trim_top
  import osc_trim_pkg::*;
#(
  parameter int DIV      = 32768,
  parameter int INTERVAL = 10,
  parameter int CODE_W   = 7,
  localparam int AMT_W = CODE_W - 1,
  localparam int SEC_W = (INTERVAL > 2) ? $clog2(INTERVAL) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              halt_i,
  input  logic              adj_load_i,
  input  logic [CODE_W-1:0] adj_code_i,
  output logic              tick_o,
  output logic              clk32_o
);
  logic [CODE_W-1:0] code_q;
  trim_dir_e         trim_dir;
  logic [AMT_W-1:0]  trim_amt;
  logic [SEC_W-1:0]  sec_q;
  logic              corr_next;

  assign clk32_o = clk_i;

  osc_trim_reg #(.CODE_W(CODE_W)) i_reg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .halt_i (halt_i),
    .load_i (adj_load_i),
    .code_i (adj_code_i),
    .code_o (code_q)
  );

  osc_trim_decode #(.CODE_W(CODE_W)) i_dec (
    .code_i (code_q),
    .dir_o  (trim_dir),
    .amt_o  (trim_amt)
  );

  osc_trim_interval #(.INTERVAL(INTERVAL)) i_int (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tick_i      (tick_o),
    .sec_o       (sec_q),
    .corr_next_o (corr_next)
  );

  osc_trim_prescaler #(.DIV(DIV), .AMT_W(AMT_W)) i_pre (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .dir_i       (trim_dir),
    .amt_i       (trim_amt),
    .corr_next_i (corr_next),
    .tick_o      (tick_o)
  );
endmodule

// File: rtl/osc_trim_chk.sv
module osc_trim_chk
  import osc_trim_pkg::*;
#(
  parameter int INTERVAL = 10,
  parameter int CODE_W   = 7,
  parameter int SEC_W    = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              halt_i,
  input logic              tick_o,
  input logic [CODE_W-1:0] code_q,
  input trim_dir_e         trim_dir,
  input logic [SEC_W-1:0]  sec_q
);
  localparam logic [CODE_W-1:0] CodeNeg  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] CodeNeg1 = {1'b1, {(CODE_W-2){1'b0}}, 1'b1};

  AST_TICK_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> !tick_o); // R1
  AST_SEC_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(sec_q) < INTERVAL); // R2
  AST_SLOW_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_dir == TRIM_SLOW) |-> !code_q[CODE_W-1]); // R3
  AST_FAST_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trim_dir == TRIM_FAST) |-> code_q[CODE_W-1]); // R4
  AST_NULL_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (code_q <= CODE_W'(1) || code_q == CodeNeg || code_q == CodeNeg1)
      |-> trim_dir == TRIM_NONE); // R5
  AST_HALT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |-> code_q == '0); // R6
endmodule

bind osc_trim_top osc_trim_chk #(
  .INTERVAL(INTERVAL), .CODE_W(CODE_W), .SEC_W(SEC_W)
) i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .halt_i   (halt_i),
  .tick_o   (tick_o),
  .code_q   (code_q),
  .trim_dir (trim_dir),
  .sec_q    (sec_q)
);

// File: tb/test_osc_trim_top.sv
`timescale 1ns/1ps
module test_osc_trim_top;
  localparam int DIV = 100;
  localparam int INTERVAL = 3;
  localparam int CODE_W = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic halt = 1'b0;
  logic load = 1'b0;
  logic [CODE_W-1:0] code = '0;
  logic tick, clk32;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  osc_trim_top #(.DIV(DIV), .INTERVAL(INTERVAL), .CODE_W(CODE_W)) i_osc_trim_top (
    .clk_i(clk), .rst_ni(rst_n), .halt_i(halt), .adj_load_i(load),
    .adj_code_i(code), .tick_o(tick), .clk32_o(clk32)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [CODE_W-1:0] c);
    int v;
    v = int'($signed(c));
    if (v >= 2) return DIV + v - 1;
    if (v <= -1 && v >= -62) return DIV + v;
    return DIV;
  endfunction

  // counts negedges until tick is seen; drops load after the first edge
  task automatic gap(output int n);
    n = 0;
    forever begin
      @(negedge clk);
      load = 1'b0;
      n++;
      if (tick) break;
    end
    @(negedge clk);
    n_vec++;
    if (tick) begin
      n_bad++;
      $display("FAIL R1 actual=%0d expected=%0d", 1, 0);
    end
    n++;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    load = 1'b0;
    repeat (2) @(negedge clk);
    chk(tick == 1'b0, "R1", int'(tick), 0);
    rst_n = 1'b1;
  endtask

  initial begin
    int g;
    do_reset();
    gap(g);
    chk(g == DIV, "R1", g, DIV);

    // sweep all codes; the code is loaded on the first edge after reset
    for (int c = 0; c < 128; c++) begin
      do_reset();
      code = CODE_W'(c);
      load = 1'b1;
      gap(g);
      chk(g == DIV, "R2", g, DIV);
      gap(g);
      chk(g == DIV, "R2", g, DIV);
      gap(g);
      if (c >= 2 && c <= 63) chk(g == exp_len(code), "R3", g, exp_len(code));
      else if (c >= 66) chk(g == exp_len(code), "R4", g, exp_len(code));
      else chk(g == DIV, "R5", g, DIV);
      gap(g);
      chk(g == DIV, "R2", g, DIV);
    end

    // halt clears the register asynchronously
    do_reset();
    code = 7'd20;
    load = 1'b1;
    gap(g);
    #1.2 halt = 1'b1;
    #0.6 halt = 1'b0;
    gap(g);
    chk(g == DIV, "R6", g, DIV);
    gap(g);
    chk(g == DIV, "R6", g, DIV);

    // code change inside a correction second
    do_reset();
    code = 7'd10;
    load = 1'b1;
    gap(g);
    gap(g);
    repeat (5) @(negedge clk);
    code = 7'd30;
    load = 1'b1;
    gap(g);
    chk(g == DIV + 9 - 5, "R8", g, DIV + 4);
    gap(g);
    chk(g == DIV, "R8", g, DIV);
    gap(g);
    chk(g == DIV, "R8", g, DIV);
    gap(g);
    chk(g == DIV + 29, "R8", g, DIV + 29);

    // negative code with the pass-through clock sampled on both phases
    do_reset();
    code = 7'b1000010;
    load = 1'b1;
    for (int i = 0; i < 8; i++) begin
      @(posedge clk); #1;
      chk(clk32 == 1'b1, "R7", int'(clk32), 1);
      @(negedge clk); #1;
      chk(clk32 == 1'b0, "R7", int'(clk32), 0);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule